// File: doc/BRIEF.md
# Read Address Pointer Controller

This block produces the read address for the read side of a frame-buffer FIFO memory. Each channel keeps a pointer that moves forward by one on every read-clock edge while its active-low read enable is low. Two active-low override inputs can change that. A clear input forces the pointer to zero. A per-channel set input loads the pointer from a shared external address bus. When clear and set are both asserted, clear wins.

Each override can be level-sensitive or falling-edge-sensitive. In level mode it acts on every edge while the input stays low. In edge mode it acts only on the one edge at which the input is first seen low, after being seen high on the edge before. A global mode pin picks the default sensitivity. Two configuration bits per input (an override enable and a sensitivity select) can replace that default. An override only takes effect when the channel's read enable was low on the previous edge. In dual-channel mode the single clear input zeroes both channel pointers. In single-channel mode it acts on channel 0 only.

Each channel is a small state machine. Its state names the action taken on the last edge: HOLD (pointer kept), STEP (pointer incremented), CLEAR (pointer zeroed) and LOAD (pointer taken from the external address). From any state the machine goes to CLEAR when a gated clear is active. Otherwise it goes to LOAD when a gated set is active, otherwise to STEP when read is enabled, otherwise to HOLD. Reset enters HOLD with the pointer at zero.

Top module: `rd_ptr_ctrl`

## Requirements
- R1: After reset, every channel's read address is zero.
- R2: With no override acting, a channel's pointer increments by one on each rising edge at which its ren_n is low, and holds while ren_n is high.
- R3: A level-sensitive clear that is low and gated zeroes the pointer on every rising edge for as long as it stays low.
- R4: An edge-sensitive clear zeroes the pointer only on the first edge at which clr_n is sampled low after being sampled high. Incrementing resumes on the following edges even while clr_n stays low.
- R5: A clear or set acts on a channel only if that channel's ren_n was sampled low on the preceding rising edge. Otherwise the override is ignored and the pointer steps or holds as R2 says.
- R6: A gated set loads the pointer with ext_addr. In level mode it reloads on every edge while set_n is low. In edge mode it loads once, on the first edge at which set_n is seen low.
- R7: With the override enable bits at 0, mode_edge = 0 makes both clear and set level-sensitive and mode_edge = 1 makes them edge-sensitive.
- R8: When cfg_clr_ovr (or cfg_set_ovr) is 1, clear (or set) is edge-sensitive if cfg_clr_edge (or cfg_set_edge) is 1 and level-sensitive if it is 0, whatever mode_edge is.
- R9: With dual_mode = 1, clr_n acts on both channel pointers. With dual_mode = 0 it acts on channel 0 only, and channel 1 keeps stepping or holding.
- R10: If a gated clear and a gated set act on the same edge, the pointer becomes zero.
- R11: Incrementing from 2^ADDR_W-1 wraps the pointer to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_edge | input | 1 | Default sensitivity: 0 level, 1 falling edge |
| cfg_clr_ovr | input | 1 | Clear sensitivity comes from cfg_clr_edge when 1 |
| cfg_clr_edge | input | 1 | Clear sensitivity when overridden: 1 edge, 0 level |
| cfg_set_ovr | input | 1 | Set sensitivity comes from cfg_set_edge when 1 |
| cfg_set_edge | input | 1 | Set sensitivity when overridden: 1 edge, 0 level |
| dual_mode | input | 1 | 1: clear drives both channels; 0: channel 0 only |
| ren_n | input | NUM_CH | Per-channel read enable, active low |
| clr_n | input | 1 | Pointer clear, active low |
| set_n | input | NUM_CH | Per-channel pointer set, active low |
| ext_addr | input | ADDR_W | Address loaded by a set |
| rd_addr | output | NUM_CH*ADDR_W | Channel read pointers, channel c at bits [c*ADDR_W +: ADDR_W] |

## Verification
The stepping function is first run with both enables held low. It is then run with the enables split, so one channel holds while the other steps, which separates per-channel gating from a shared enable. Clear and set are each held low for several edges in level mode and in edge mode, so a one-shot is told apart from a held override. Overrides are also applied right after a disabled cycle, which shows whether the gate uses the previous edge's enable or the current one. Combinations of the mode pin and the override bits, clear and set asserted together, single and dual mode, and a load to all ones followed by a step test the remaining corners. A long stretch of pseudo-random stimulus is then compared each cycle against a behavioural model.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    // Action taken by a channel on the most recent read-clock edge
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_STEP  = 2'd1,
        ST_CLEAR = 2'd2,
        ST_LOAD  = 2'd3
    } rpc_state_e;

    // Sensitivity selection for one override input
    typedef struct packed {
        logic ovr_en;
        logic ovr_edge;
    } rpc_sens_t;

    function automatic logic rpc_pick_edge(input logic mode_pin, input rpc_sens_t s);
        return s.ovr_en ? s.ovr_edge : mode_pin;
    endfunction

endpackage

// File: rtl/rpc_trig_detect.sv
module rpc_trig_detect
    import rpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_n,
    input  logic      mode_pin,
    input  rpc_sens_t sens,
    output logic      active,
    output logic      edge_sel
);

    logic prev_q;

    // Previous sampled value; idle high so reset never looks like a fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_n;
    end

    always_comb begin
        edge_sel = rpc_pick_edge(mode_pin, sens);
        if (edge_sel) active = prev_q & ~sig_n;
        else          active = ~sig_n;
    end

    // Edge mode yields a single-cycle pulse
    AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && edge_sel) |=> (!active || !edge_sel)); // R4

endmodule

// File: rtl/rpc_chan_fsm.sv
module rpc_chan_fsm
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_n,
    input  logic              clr_trig,
    input  logic              set_trig,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] ptr
);

    typedef logic [ADDR_W-1:0] ptr_t;
    localparam ptr_t PTR_ONE = ptr_t'(1);

    rpc_state_e state_q, state_d;
    logic       ren_q_n;
    logic       gate_ok;
    logic       clr_go, set_go;

    // Previous-edge enable qualifies overrides
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ren_q_n <= 1'b1;
        else        ren_q_n <= ren_n;
    end

    assign gate_ok = ~ren_q_n;
    assign clr_go  = clr_trig & gate_ok;
    assign set_go  = set_trig & gate_ok;

    // Next-state selection: clear over set over step
    always_comb begin
        if (clr_go)      state_d = ST_CLEAR;
        else if (set_go) state_d = ST_LOAD;
        else if (!ren_n) state_d = ST_STEP;
        else             state_d = ST_HOLD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Output register: pointer follows the chosen action
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            unique case (state_d)
                ST_HOLD:  ptr <= ptr;
                ST_STEP:  ptr <= ptr + PTR_ONE;
                ST_CLEAR: ptr <= '0;
                ST_LOAD:  ptr <= ext_addr;
            endcase
        end
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_n && !clr_go && !set_go) |=> (ptr == $past(ptr) + PTR_ONE)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (ptr == '0)); // R10
    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (ptr == '0)); // R3
    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_go && !clr_go) |=> (ptr == $past(ext_addr))); // R6
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_n && ren_q_n) |=> $stable(ptr)); // R5

endmodule

// File: rtl/rd_ptr_ctrl.sv
module rd_ptr_ctrl
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_edge,
    input  logic                     cfg_clr_ovr,
    input  logic                     cfg_clr_edge,
    input  logic                     cfg_set_ovr,
    input  logic                     cfg_set_edge,
    input  logic                     dual_mode,
    input  logic [NUM_CH-1:0]        ren_n,
    input  logic                     clr_n,
    input  logic [NUM_CH-1:0]        set_n,
    input  logic [ADDR_W-1:0]        ext_addr,
    output logic [NUM_CH*ADDR_W-1:0] rd_addr
);

    localparam int BUS_W = NUM_CH * ADDR_W;

    rpc_sens_t   clr_sens, set_sens;
    logic        clr_act;
    logic        clr_is_edge;
    logic [NUM_CH-1:0] set_act;
    logic [NUM_CH-1:0] set_is_edge;
    logic [NUM_CH-1:0] chan_clr;

    assign clr_sens = '{ovr_en: cfg_clr_ovr, ovr_edge: cfg_clr_edge};
    assign set_sens = '{ovr_en: cfg_set_ovr, ovr_edge: cfg_set_edge};

    // One shared clear detector feeds every channel
    rpc_trig_detect u_clr_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_n    (clr_n),
        .mode_pin (mode_edge),
        .sens     (clr_sens),
        .active   (clr_act),
        .edge_sel (clr_is_edge)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [ADDR_W-1:0] ch_ptr;

        if (c == 0) begin : g_primary
            assign chan_clr[c] = clr_act;
        end else begin : g_secondary
            assign chan_clr[c] = clr_act & dual_mode;
        end

        rpc_trig_detect u_set_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_n    (set_n[c]),
            .mode_pin (mode_edge),
            .sens     (set_sens),
            .active   (set_act[c]),
            .edge_sel (set_is_edge[c])
        );

        rpc_chan_fsm #(.ADDR_W(ADDR_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ren_n    (ren_n[c]),
            .clr_trig (chan_clr[c]),
            .set_trig (set_act[c]),
            .ext_addr (ext_addr),
            .ptr      (ch_ptr)
        );

        assign rd_addr[c*ADDR_W +: ADDR_W] = ch_ptr;
    end

    // Sensitivity selects agree across set detectors
    AST_SET_SENS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_is_edge == {NUM_CH{set_is_edge[0]}})); // R8
    AST_RESET_ZERO: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_addr == BUS_W'(0))); // R1
    AST_CLR_EDGE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_clr_ovr) |-> (clr_is_edge == mode_edge)); // R7

endmodule

// File: tb/rd_ptr_ctrl_test.sv
module rd_ptr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_edge = 1'b0;
    logic cfg_clr_ovr = 1'b0, cfg_clr_edge = 1'b0;
    logic cfg_set_ovr = 1'b0, cfg_set_edge = 1'b0;
    logic dual_mode = 1'b1;
    logic [NC-1:0] ren_n = '1;
    logic clr_n = 1'b1;
    logic [NC-1:0] set_n = '1;
    logic [AW-1:0] ext_addr = '0;
    logic [NC*AW-1:0] rd_addr;

    int tests = 0;
    int fails = 0;
    string tag = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_ptr_ctrl #(.ADDR_W(AW), .NUM_CH(NC)) uut (
        .clk(clk), .rst_n(rst_n), .mode_edge(mode_edge),
        .cfg_clr_ovr(cfg_clr_ovr), .cfg_clr_edge(cfg_clr_edge),
        .cfg_set_ovr(cfg_set_ovr), .cfg_set_edge(cfg_set_edge),
        .dual_mode(dual_mode), .ren_n(ren_n), .clr_n(clr_n),
        .set_n(set_n), .ext_addr(ext_addr), .rd_addr(rd_addr)
    );

    // Behavioural reference model
    logic [AW-1:0] m_ptr [NC];
    bit m_ren_prev [NC];
    bit m_set_prev [NC];
    bit m_clr_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_ptr[c] = '0; m_ren_prev[c] = 1; m_set_prev[c] = 1;
            end
            m_clr_prev = 1;
        end else begin
            bit clr_edge_mode, set_edge_mode, clr_on;
            clr_edge_mode = cfg_clr_ovr ? cfg_clr_edge : mode_edge;
            set_edge_mode = cfg_set_ovr ? cfg_set_edge : mode_edge;
            clr_on = clr_edge_mode ? (m_clr_prev && !clr_n) : !clr_n;
            for (int c = 0; c < NC; c++) begin
                bit set_on, allowed, this_clr;
                set_on = set_edge_mode ? (m_set_prev[c] && !set_n[c]) : !set_n[c];
                allowed = (m_ren_prev[c] == 0);
                this_clr = clr_on && (c == 0 || dual_mode);
                if (allowed && this_clr)     m_ptr[c] = 0;
                else if (allowed && set_on)  m_ptr[c] = ext_addr;
                else if (!ren_n[c])          m_ptr[c] = m_ptr[c] + 1;
                m_ren_prev[c] = ren_n[c];
                m_set_prev[c] = set_n[c];
            end
            m_clr_prev = clr_n;
        end
    end

    task automatic check(input string t, input int c, input logic [AW-1:0] exp);
        logic [AW-1:0] act;
        act = rd_addr[c*AW +: AW];
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d actual=%h expected=%h", t, c, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done)
            for (int c = 0; c < NC; c++) check(tag, c, m_ptr[c]);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check("R1", 0, 0); check("R1", 1, 0);

        tag = "R2";
        ren_n = 2'b00; tick(5);
        check("R2", 0, 5); check("R2", 1, 5);
        ren_n = 2'b01; tick(3);
        check("R2", 0, 5); check("R2", 1, 8);
        ren_n = 2'b00; tick(1);

        tag = "R3"; // level clear, default from mode pin (R7)
        mode_edge = 1'b0; clr_n = 1'b0; tick(3);
        check("R3", 0, 0); check("R3", 1, 0);
        clr_n = 1'b1; tick(1);
        check("R3", 0, 1);

        tag = "R4"; // edge clear
        mode_edge = 1'b1; tick(2);
        clr_n = 1'b0; tick(1);
        check("R4", 0, 0);
        tick(2);
        check("R4", 0, 2);
        clr_n = 1'b1; tick(1);

        tag = "R5"; // previous-edge enable gate
        ren_n = 2'b11; tick(1);
        ren_n = 2'b00; clr_n = 1'b0; tick(1);
        check("R5", 0, 4);
        tick(1);
        clr_n = 1'b1; tick(1);

        tag = "R6"; // set level then edge
        mode_edge = 1'b0; ext_addr = 24'h123456; set_n = 2'b00; tick(3);
        check("R6", 0, 24'h123456);
        set_n = 2'b11; tick(1);
        check("R6", 0, 24'h123457);
        tag = "R7";
        mode_edge = 1'b1; ext_addr = 24'hABCDEF; set_n = 2'b00; tick(1);
        check("R7", 0, 24'hABCDEF);
        tick(1);
        check("R7", 0, 24'hABCDF0);
        set_n = 2'b11; tick(1);

        tag = "R8"; // override bits
        cfg_set_ovr = 1'b1; cfg_set_edge = 1'b0; ext_addr = 24'h000100;
        set_n = 2'b00; tick(2);
        check("R8", 0, 24'h000100);
        set_n = 2'b11; mode_edge = 1'b0;
        cfg_clr_ovr = 1'b1; cfg_clr_edge = 1'b1; tick(1);
        clr_n = 1'b0; tick(2);
        check("R8", 0, 1);
        clr_n = 1'b1; cfg_clr_ovr = 1'b0; cfg_set_ovr = 1'b0; tick(1);

        tag = "R9"; // single-channel clear
        dual_mode = 1'b0; tick(2);
        clr_n = 1'b0; tick(1);
        check("R9", 0, 0);
        tick(1);
        clr_n = 1'b1; dual_mode = 1'b1; tick(1);

        tag = "R10"; // clear beats set
        ext_addr = 24'h777777; clr_n = 1'b0; set_n = 2'b00; tick(1);
        check("R10", 0, 0); check("R10", 1, 0);
        clr_n = 1'b1; set_n = 2'b11; tick(1);

        tag = "R11"; // wrap
        mode_edge = 1'b1; ext_addr = '1; set_n = 2'b00; tick(1);
        check("R11", 0, 24'hFFFFFF);
        set_n = 2'b11; tick(1);
        check("R11", 0, 24'h000000);

        tag = "R5"; // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            ren_n = r[1:0] & {r[8], r[8]};
            clr_n = r[2] | r[3] | r[9];
            set_n = {r[4] | r[10], r[5] | r[11]};
            mode_edge = r[6];
            cfg_clr_ovr = r[12]; cfg_clr_edge = r[13];
            cfg_set_ovr = r[14]; cfg_set_edge = r[15];
            dual_mode = r[7];
            ext_addr = r[31:8];
            tick(1);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule